// File: doc/BRIEF.md
# Cache snoop response controller

This block answers snoop requests that an external agent makes against a write-back capable data cache. When the snoop strobe is high, the controller takes a line address (the upper 28 bits of a 32-bit byte address, so a line is 16 bytes) and an invalidate-request bit. It looks the line up in a small direct-mapped tag/state/data model and reports the result one cycle later. The line's current state and the invalidate bit together decide what happens. The line may be left alone, dropped at once, or written back in a four-beat burst on a simple bus master port. After a burst the line is either kept as clean write-back or invalidated.

Each line holds one of four states: invalid, write-through-only, clean write-back or modified. A hit on a modified line raises the hit-modified output. It also opens the burst with a one-cycle address strobe and cacheable flag. Hit-modified and busy then stay high until the last beat has been accepted by the bus ready input. While busy, further snoop strobes are not accepted. A fill port installs lines into the model. It stands in for the CPU-side allocation path that the block does not contain.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every line to invalid and drives rsp_valid, hit_mod, busy, bus_ads, bus_cache, bus_addr and bus_wdata to zero.
- R2: One cycle after an accepted snoop strobe, rsp_valid is high for one cycle. rsp_hit is high only if the set indexed by snp_line[3:0] is not invalid and holds the tag snp_line[27:4].
- R3: A snoop that hits a modified line raises hit_mod in the cycle after the strobe. hit_mod stays high until the edge on which the fourth beat completes, and is low from the next cycle.
- R4: The first cycle of a write-back burst shows bus_ads, bus_cache and hit_mod high together. bus_ads and bus_cache are high for that single cycle only.
- R5: A burst has four beats. Beat b drives bus_addr = {line, b[1:0], 2'b00} and bus_wdata = fill_data[32*b+31:32*b] of the installed line. A beat advances only on a clock edge where bus_ready is high, and bus_addr holds otherwise.
- R6: With invalidate set and the line modified, the line reads as invalid once the burst has finished.
- R7: With invalidate clear and the line modified, the line reads as clean write-back (code 2) once the burst has finished.
- R8: With invalidate set, a write-through-only or clean write-back line becomes invalid at the snoop edge, and no burst starts.
- R9: With invalidate clear, a snoop leaves a write-through-only or clean write-back line unchanged and starts no burst.
- R10: snp_inv has no effect unless snp_strobe is high in the same cycle.
- R11: busy is high exactly while a burst is in progress. A snoop strobe during that time gives no rsp_valid and changes no line.
- R12: rsp_state reports the looked-up line state as 0 invalid, 1 write-through-only, 2 clean write-back, 3 modified. A fill_en cycle installs fill_line with fill_state and fill_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_strobe | input | 1 | Snoop request strobe |
| snp_inv | input | 1 | Invalidate request, valid with the strobe |
| snp_line | input | 28 | Snooped line address (byte address bits 31:4) |
| fill_en | input | 1 | Install a line into the model |
| fill_line | input | 28 | Line address to install |
| fill_state | input | 2 | State code of the installed line |
| fill_data | input | 128 | Line contents, word 0 in the low bits |
| bus_ready | input | 1 | Current burst beat completes |
| rsp_valid | output | 1 | Snoop response valid |
| rsp_hit | output | 1 | Snooped line present |
| rsp_state | output | 2 | State of the snooped line at lookup |
| hit_mod | output | 1 | Snoop hit a modified line, write-back pending |
| busy | output | 1 | Write-back burst in progress |
| bus_ads | output | 1 | Burst address strobe |
| bus_cache | output | 1 | Cacheable indication for the burst |
| bus_addr | output | 32 | Byte address of the current beat |
| bus_wdata | output | 32 | Data word of the current beat |

## Verification
The hardest case to create from the ports is a second snoop arriving while a write-back burst is still open. That snoop must not be accepted and must not touch the line it names. The bench gets there by holding bus_ready low right after a modified-line hit. It then strobes an invalidating snoop at a different write-through-only line, finishes the burst, and probes that line to show that its state is unchanged. The state changes after a burst are seen only through a later probe snoop. So each table row installs a line, snoops it, drains any burst with stalls on chosen beats, and then probes the line again.

// File: rtl/snp_pkg.sv
`timescale 1ns/1ps
package snp_pkg;

    localparam int unsigned LINE_ADDR_W    = 28;
    localparam int unsigned SET_IDX_W      = 4;
    localparam int unsigned BEATS_PER_LINE = 4;
    localparam int unsigned WORD_BITS      = 32;

    typedef enum logic [1:0] {
        LS_INVALID = 2'd0,
        LS_WTHRU   = 2'd1,
        LS_CLEAN   = 2'd2,
        LS_DIRTY   = 2'd3
    } line_state_e;

    typedef struct packed {
        logic        hit;
        line_state_e state;
    } lookup_t;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_DROP    = 2'd1,
        ACT_WB_KEEP = 2'd2,
        ACT_WB_DROP = 2'd3
    } snoop_act_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WB   = 1'b1
    } ctl_phase_e;

    function automatic snoop_act_e pick_action(input lookup_t res, input logic inv);
        if (!res.hit) begin
            return ACT_NONE;
        end
        if (res.state == LS_DIRTY) begin
            return inv ? ACT_WB_DROP : ACT_WB_KEEP;
        end
        return inv ? ACT_DROP : ACT_NONE;
    endfunction

    function automatic logic needs_writeback(input snoop_act_e act);
        return (act == ACT_WB_KEEP) || (act == ACT_WB_DROP);
    endfunction

    function automatic line_state_e after_writeback(input logic inv);
        return inv ? LS_INVALID : LS_CLEAN;
    endfunction

endpackage

// File: rtl/snp_tag_array.sv
`timescale 1ns/1ps
module snp_tag_array
    import snp_pkg::*;
#(
    parameter int unsigned LINE_AW   = LINE_ADDR_W,
    parameter int unsigned SET_W     = SET_IDX_W,
    parameter int unsigned LINE_BITS = BEATS_PER_LINE * WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LINE_AW-1:0]   look_line,
    output lookup_t              look_res,
    output logic [LINE_BITS-1:0] look_data,
    input  logic                 fill_en,
    input  logic [LINE_AW-1:0]   fill_line,
    input  line_state_e          fill_state,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic                 upd_en,
    input  logic [SET_W-1:0]     upd_set,
    input  line_state_e          upd_state
);
    localparam int unsigned SETS  = 1 << SET_W;
    localparam int unsigned TAG_W = LINE_AW - SET_W;

    logic [TAG_W-1:0]     tag_q [SETS];
    line_state_e          st_q  [SETS];
    logic [LINE_BITS-1:0] dat_q [SETS];

    logic [SET_W-1:0] fill_set;
    logic [TAG_W-1:0] fill_tag;
    logic [SET_W-1:0] look_set;
    logic [TAG_W-1:0] look_tag;

    assign fill_set = fill_line[SET_W-1:0];
    assign fill_tag = fill_line[LINE_AW-1:SET_W];
    assign look_set = look_line[SET_W-1:0];
    assign look_tag = look_line[LINE_AW-1:SET_W];

    // State and tag: a snoop update wins over a fill to the same set.
    always_ff @(posedge clk) begin
        for (int s = 0; s < int'(SETS); s++) begin
            if (rst) begin
                st_q[s]  <= LS_INVALID;
                tag_q[s] <= '0;
            end else if (upd_en && (upd_set == SET_W'(s))) begin
                st_q[s] <= upd_state;
            end else if (fill_en && (fill_set == SET_W'(s))) begin
                st_q[s]  <= fill_state;
                tag_q[s] <= fill_tag;
            end
        end
    end

    // Line contents are written only by fills.
    always_ff @(posedge clk) begin
        for (int s = 0; s < int'(SETS); s++) begin
            if (fill_en && (fill_set == SET_W'(s))) begin
                dat_q[s] <= fill_data;
            end
        end
    end

    always_comb begin
        look_res.hit   = (st_q[look_set] != LS_INVALID) && (tag_q[look_set] == look_tag);
        look_res.state = look_res.hit ? st_q[look_set] : LS_INVALID;
        look_data      = dat_q[look_set];
    end

endmodule

// File: rtl/snp_wb_burst.sv
`timescale 1ns/1ps
module snp_wb_burst
    import snp_pkg::*;
#(
    parameter int unsigned LINE_AW = LINE_ADDR_W,
    parameter int unsigned BEATS   = BEATS_PER_LINE,
    parameter int unsigned WORD_W  = WORD_BITS
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    start,
    input  logic [LINE_AW-1:0]                      start_line,
    input  logic [BEATS*WORD_W-1:0]                 start_data,
    input  logic                                    bus_ready,
    output logic                                    active,
    output logic                                    ads,
    output logic [LINE_AW+$clog2(BEATS)+$clog2(WORD_W/8)-1:0] addr,
    output logic [WORD_W-1:0]                       wdata,
    output logic                                    last_beat
);
    localparam int unsigned BEAT_W    = $clog2(BEATS);
    localparam int unsigned BYTE_W    = $clog2(WORD_W / 8);
    localparam int unsigned LINE_BITS = BEATS * WORD_W;

    logic                 active_q;
    logic                 ads_q;
    logic [BEAT_W-1:0]    beat_q;
    logic [LINE_AW-1:0]   line_q;
    logic [LINE_BITS-1:0] data_q;
    logic [WORD_W-1:0]    words [BEATS];

    for (genvar g = 0; g < int'(BEATS); g++) begin : g_word
        assign words[g] = data_q[g*WORD_W +: WORD_W];
    end

    assign last_beat = active_q && bus_ready && (beat_q == BEAT_W'(BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            ads_q    <= 1'b0;
            beat_q   <= '0;
            line_q   <= '0;
            data_q   <= '0;
        end else if (start && !active_q) begin
            active_q <= 1'b1;
            ads_q    <= 1'b1;
            beat_q   <= '0;
            line_q   <= start_line;
            data_q   <= start_data;
        end else if (active_q) begin
            ads_q <= 1'b0;
            if (bus_ready) begin
                if (last_beat) begin
                    active_q <= 1'b0;
                    beat_q   <= '0;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
        end
    end

    assign active = active_q;
    assign ads    = ads_q;
    assign addr   = active_q ? {line_q, beat_q, BYTE_W'(0)} : '0;
    assign wdata  = active_q ? words[beat_q] : '0;

endmodule

// File: rtl/snp_ctrl.sv
`timescale 1ns/1ps
module snp_ctrl
    import snp_pkg::*;
#(
    parameter int unsigned SET_W = SET_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_strobe,
    input  logic             snp_inv,
    input  logic [SET_W-1:0] snp_set,
    input  lookup_t          look_res,
    input  logic             burst_last,
    output logic             burst_start,
    output logic             upd_en,
    output logic [SET_W-1:0] upd_set,
    output line_state_e      upd_state,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output line_state_e      rsp_state,
    output logic             hit_mod
);
    ctl_phase_e       phase_q;
    logic             inv_q;
    logic [SET_W-1:0] set_q;
    logic             rsp_valid_q;
    lookup_t          rsp_q;
    logic             accept;
    snoop_act_e       act;

    assign accept = snp_strobe && (phase_q == PH_IDLE);

    always_comb begin
        act         = pick_action(look_res, snp_inv);
        burst_start = accept && needs_writeback(act);
        upd_en      = 1'b0;
        upd_set     = snp_set;
        upd_state   = LS_INVALID;
        if ((phase_q == PH_WB) && burst_last) begin
            upd_en    = 1'b1;
            upd_set   = set_q;
            upd_state = after_writeback(inv_q);
        end else if (accept && (act == ACT_DROP)) begin
            upd_en    = 1'b1;
            upd_set   = snp_set;
            upd_state = LS_INVALID;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            inv_q       <= 1'b0;
            set_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_q       <= '{hit: 1'b0, state: LS_INVALID};
        end else begin
            rsp_valid_q <= accept;
            if (accept) begin
                rsp_q <= look_res;
            end
            unique case (phase_q)
                PH_IDLE: if (burst_start) begin
                    phase_q <= PH_WB;
                    inv_q   <= snp_inv;
                    set_q   <= snp_set;
                end
                PH_WB: if (burst_last) begin
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_state = rsp_q.state;
    assign hit_mod   = (phase_q == PH_WB);

endmodule

// File: rtl/snoop_resp_ctrl.sv
`timescale 1ns/1ps
module snoop_resp_ctrl
    import snp_pkg::*;
#(
    parameter int unsigned LINE_AW = LINE_ADDR_W,
    parameter int unsigned SET_W   = SET_IDX_W,
    parameter int unsigned BEATS   = BEATS_PER_LINE,
    parameter int unsigned WORD_W  = WORD_BITS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      snp_strobe,
    input  logic                      snp_inv,
    input  logic [LINE_AW-1:0]        snp_line,
    input  logic                      fill_en,
    input  logic [LINE_AW-1:0]        fill_line,
    input  logic [1:0]                fill_state,
    input  logic [BEATS*WORD_W-1:0]   fill_data,
    input  logic                      bus_ready,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [1:0]                rsp_state,
    output logic                      hit_mod,
    output logic                      busy,
    output logic                      bus_ads,
    output logic                      bus_cache,
    output logic [LINE_AW+$clog2(BEATS)+$clog2(WORD_W/8)-1:0] bus_addr,
    output logic [WORD_W-1:0]         bus_wdata
);
    localparam int unsigned LINE_BITS = BEATS * WORD_W;

    lookup_t              look_res;
    logic [LINE_BITS-1:0] look_data;
    logic                 upd_en;
    logic [SET_W-1:0]     upd_set;
    line_state_e          upd_state;
    logic                 burst_start;
    logic                 burst_last;
    logic                 burst_active;
    logic                 burst_ads;
    line_state_e          rsp_state_e;

    snp_tag_array #(
        .LINE_AW  (LINE_AW),
        .SET_W    (SET_W),
        .LINE_BITS(LINE_BITS)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .look_line (snp_line),
        .look_res  (look_res),
        .look_data (look_data),
        .fill_en   (fill_en),
        .fill_line (fill_line),
        .fill_state(line_state_e'(fill_state)),
        .fill_data (fill_data),
        .upd_en    (upd_en),
        .upd_set   (upd_set),
        .upd_state (upd_state)
    );

    snp_ctrl #(
        .SET_W(SET_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .snp_strobe (snp_strobe),
        .snp_inv    (snp_inv),
        .snp_set    (snp_line[SET_W-1:0]),
        .look_res   (look_res),
        .burst_last (burst_last),
        .burst_start(burst_start),
        .upd_en     (upd_en),
        .upd_set    (upd_set),
        .upd_state  (upd_state),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_state  (rsp_state_e),
        .hit_mod    (hit_mod)
    );

    snp_wb_burst #(
        .LINE_AW(LINE_AW),
        .BEATS  (BEATS),
        .WORD_W (WORD_W)
    ) u_burst (
        .clk       (clk),
        .rst       (rst),
        .start     (burst_start),
        .start_line(snp_line),
        .start_data(look_data),
        .bus_ready (bus_ready),
        .active    (burst_active),
        .ads       (burst_ads),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .last_beat (burst_last)
    );

    assign rsp_state = rsp_state_e;
    assign busy      = burst_active;
    assign bus_ads   = burst_ads;
    assign bus_cache = burst_ads;

endmodule

// File: rtl/snp_checker.sv
`timescale 1ns/1ps
module snp_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              snp_strobe,
    input logic              bus_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [1:0]        rsp_state,
    input logic              hit_mod,
    input logic              busy,
    input logic              bus_ads,
    input logic              bus_cache,
    input logic [ADDR_W-1:0] bus_addr
);
    assert_resp_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(snp_strobe));

    assert_hitmod_in_burst_R3: assert property (@(posedge clk) disable iff (rst)
        hit_mod |-> busy);

    assert_dirty_raises_hitmod_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && (rsp_state == 2'd3)) |-> hit_mod);

    assert_start_marked_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (bus_ads && bus_cache && hit_mod));

    assert_ads_single_R4: assert property (@(posedge clk) disable iff (rst)
        bus_ads |=> !bus_ads);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_ready) |=> $stable(bus_addr));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_ads && !bus_cache && (bus_addr == '0)));

    assert_ignore_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && snp_strobe) |=> !rsp_valid);

endmodule

bind snoop_resp_ctrl snp_checker #(.ADDR_W(32)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .snp_strobe(snp_strobe),
    .bus_ready (bus_ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_state (rsp_state),
    .hit_mod   (hit_mod),
    .busy      (busy),
    .bus_ads   (bus_ads),
    .bus_cache (bus_cache),
    .bus_addr  (bus_addr)
);

// File: tb/sim_snoop_resp_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_resp_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         snp_strobe = 1'b0;
    logic         snp_inv = 1'b0;
    logic [27:0]  snp_line = '0;
    logic         fill_en = 1'b0;
    logic [27:0]  fill_line = '0;
    logic [1:0]   fill_state = '0;
    logic [127:0] fill_data = '0;
    logic         bus_ready = 1'b0;
    logic         rsp_valid, rsp_hit, hit_mod, busy, bus_ads, bus_cache;
    logic [1:0]   rsp_state;
    logic [31:0]  bus_addr, bus_wdata;

    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    snoop_resp_ctrl u0 (
        .clk(clk), .rst(rst), .snp_strobe(snp_strobe), .snp_inv(snp_inv),
        .snp_line(snp_line), .fill_en(fill_en), .fill_line(fill_line),
        .fill_state(fill_state), .fill_data(fill_data), .bus_ready(bus_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_state(rsp_state),
        .hit_mod(hit_mod), .busy(busy), .bus_ads(bus_ads), .bus_cache(bus_cache),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );

    // Fields: {state[1:0], inv, exp_hit, exp_hitmod, exp_final[1:0]}
    localparam logic [6:0] VECS [8] = '{
        7'b00_0_0_0_00, 7'b00_1_0_0_00,
        7'b01_0_1_0_01, 7'b01_1_1_0_00,
        7'b10_0_1_0_10, 7'b10_1_1_0_00,
        7'b11_0_1_1_10, 7'b11_1_1_1_00
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] line_data(input logic [27:0] l);
        logic [127:0] d;
        for (int w = 0; w < 4; w++) d[w*32 +: 32] = {l[15:0], 16'hA000 + 16'(w)};
        return d;
    endfunction

    task automatic fill(input logic [27:0] l, input logic [1:0] st);
        fill_en = 1'b1; fill_line = l; fill_state = st; fill_data = line_data(l);
        tick();
        fill_en = 1'b0;
    endtask

    task automatic snoop(input logic [27:0] l, input logic inv);
        snp_strobe = 1'b1; snp_inv = inv; snp_line = l;
        tick();
        snp_strobe = 1'b0; snp_inv = 1'b0;
    endtask

    task automatic run_burst(input logic [27:0] l, input logic ads0);
        for (int b = 0; b < 4; b++) begin
            chk("R3", "hit_mod in burst", hit_mod, 1'b1);
            chk("R5", "beat addr", bus_addr, {l, 2'(b), 2'b00});
            chk("R5", "beat data", bus_wdata, {l[15:0], 16'hA000 + 16'(b)});
            chk("R4", "ads per beat", bus_ads, (b == 0) ? ads0 : 1'b0);
            chk("R4", "cache per beat", bus_cache, (b == 0) ? ads0 : 1'b0);
            bus_ready = 1'b0;
            for (int s = 0; s < b; s++) begin
                tick();
                chk("R5", "addr held in stall", bus_addr, {l, 2'(b), 2'b00});
                chk("R3", "hit_mod in stall", hit_mod, 1'b1);
            end
            bus_ready = 1'b1;
            tick();
            bus_ready = 1'b0;
        end
        chk("R3", "hit_mod after last beat", hit_mod, 1'b0);
        chk("R11", "busy after last beat", busy, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [27:0] l;
        string fin_req;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset values
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "hit_mod", hit_mod, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "bus_ads", bus_ads, 0);
        chk("R1", "bus_addr", bus_addr, 0);
        chk("R1", "bus_wdata", bus_wdata, 0);
        snoop(28'h0000007, 1'b0);
        chk("R1", "empty array miss", rsp_hit, 0);

        // Table of state x invalidate combinations
        for (int i = 0; i < 8; i++) begin
            logic [6:0] v;
            v = VECS[i];
            l = 28'h00C0DE0 + 28'(i);
            fill(l, v[6:5]);
            snoop(l, v[4]);
            chk("R2", "rsp_valid", rsp_valid, 1'b1);
            chk("R2", "rsp_hit", rsp_hit, v[3]);
            chk("R12", "rsp_state", rsp_state, v[6:5]);
            chk("R3", "hit_mod", hit_mod, v[2]);
            chk("R4", "bus_ads", bus_ads, v[2]);
            chk("R4", "bus_cache", bus_cache, v[2]);
            chk("R11", "busy", busy, v[2]);
            if (v[2]) run_burst(l, 1'b1);
            tick();
            chk("R2", "no repeat rsp", rsp_valid, 1'b0);
            if (v[6:5] == 2'd3) fin_req = v[4] ? "R6" : "R7";
            else               fin_req = v[4] ? "R8" : "R9";
            snoop(l, 1'b0);
            chk(fin_req, "probe hit", rsp_hit, (v[1:0] != 2'd0));
            chk(fin_req, "probe state", rsp_state, v[1:0]);
            chk(fin_req, "probe no burst", busy, 1'b0);
        end

        // R2: same set, different tag misses
        fill(28'h001234B, 2'd1);
        snoop(28'h003434B, 1'b1);
        chk("R2", "tag mismatch hit", rsp_hit, 1'b0);
        chk("R2", "tag mismatch busy", busy, 1'b0);
        snoop(28'h001234B, 1'b0);
        chk("R2", "tag match after mismatch", rsp_hit, 1'b1);

        // R10: invalidate without strobe is ignored
        fill(28'h00CCCCA, 2'd1);
        snp_line = 28'h00CCCCA; snp_inv = 1'b1;
        repeat (3) tick();
        chk("R10", "no rsp without strobe", rsp_valid, 1'b0);
        snp_inv = 1'b0;
        snoop(28'h00CCCCA, 1'b0);
        chk("R10", "line kept", rsp_state, 2'd1);

        // R11: strobe during burst is ignored
        fill(28'h00AAAA8, 2'd3);
        fill(28'h00BBBB9, 2'd1);
        snoop(28'h00AAAA8, 1'b0);
        chk("R11", "busy on dirty hit", busy, 1'b1);
        snoop(28'h00BBBB9, 1'b1);
        chk("R11", "no rsp while busy", rsp_valid, 1'b0);
        run_burst(28'h00AAAA8, 1'b0);
        snoop(28'h00BBBB9, 1'b0);
        chk("R11", "ignored line still present", rsp_hit, 1'b1);
        chk("R11", "ignored line state", rsp_state, 2'd1);
        snoop(28'h00AAAA8, 1'b0);
        chk("R7", "kept line clean", rsp_state, 2'd2);

        // R1: reset clears installed lines
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        snoop(28'h00C0DE2, 1'b0);
        chk("R1", "line cleared by reset", rsp_hit, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule